// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Per-Sub-Block Validity

This block is a small direct-mapped data cache between a processor load/store port and a slower memory. Every 32-byte frame keeps one tag and four valid flags, one flag for each 8-byte sub-block. A lookup therefore has three outcomes: a hit, a miss where the tag differs, and a miss where the tag matches but the addressed sub-block has never been loaded. In both miss cases only the 8 bytes of the addressed sub-block are fetched. Each frame has exactly one possible home for a given address, so the cache never has to pick a victim.

The processor port uses a valid/ready handshake with a 32-bit address, a 32-bit write word and four byte enables. While `cpu_req_ready` is low the processor holds its request unchanged. Read data comes back one cycle after acceptance. Stores are write-through: each accepted store becomes one word write on the memory port, and the processor waits until that write is taken. A mode input selects whether a store miss first loads its sub-block (allocate) or bypasses the cache. A clear input drops all cached contents at once.

The memory port carries two kinds of request on one valid/ready channel: 8-byte sub-block reads and 4-byte word writes with byte enables. A read is answered later by a single-cycle response that carries the whole 64-bit sub-block.

Top module: `subblk_dm_cache`

## Requirements
- R1: The address splits into a byte offset in bits 4:0, a frame index in bits 9:5 and a tag in bits 31:10. Within the offset, bits 4:3 pick the sub-block and bit 2 picks the 32-bit word inside it. An address maps only to frame (address / 32) mod 32.
- R2: A read hits only if the stored tag of its frame matches and the valid flag of its sub-block is set. A read hit is accepted in the same cycle with `cpu_req_ready` high, and `cpu_rsp_valid` pulses for one cycle on the next cycle with the word in `cpu_rsp_rdata`.
- R3: On a read miss, `cpu_req_ready` stays low and exactly one memory request is issued with `mem_req_we` = 0 and the address rounded down to 8 bytes. The response data holds byte k of the sub-block in bits 8k+7:8k, so the word with address bit 2 set occupies bits 63:32.
- R4: When the refill completes, the held request is replayed as a hit. It is accepted with no further memory read, and its returned word equals the memory contents.
- R5: A refill into a frame whose tag differs writes the new tag and leaves only the refilled sub-block valid. A later read of any other sub-block of that frame then misses, whichever of the old and new tags it carries.
- R6: A refill into a frame whose tag already matches sets only the refilled sub-block's flag. Sub-blocks that were valid before stay valid and still hit.
- R7: Every accepted store issues one memory write with `mem_req_we` = 1, the address with bits 1:0 cleared, and the same data and byte enables. `cpu_req_ready` stays low until the memory port takes that write.
- R8: A store hit changes only the bytes whose `cpu_req_be` bit is set (bit k covers data bits 8k+7:8k). The other bytes of the cached word keep their values.
- R9: With `wr_alloc` = 1, a store miss first refills its sub-block as in R3 and R5, then is replayed as a hit, so a following read of that address hits and returns the merged word.
- R10: With `wr_alloc` = 0, a store miss is accepted with no refill and leaves tags and valid flags untouched. It only updates memory, and a line that was cached in that frame keeps hitting.
- R11: A one-cycle pulse on `inval` clears every valid flag, so each following read misses. The clear wins over a refill that completes in the same cycle.
- R12: After reset every valid flag is clear, no memory request is pending and `cpu_rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval | input | 1 | Clear all valid flags |
| wr_alloc | input | 1 | 1: store misses load their sub-block; 0: store misses bypass |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid is also high |
| cpu_req_we | input | 1 | 1 store, 0 load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 word write, 0 sub-block read |
| mem_req_addr | output | 32 | Request byte address (8-aligned for reads, 4-aligned for writes) |
| mem_req_wdata | output | 32 | Write word |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Sub-block read data present |
| mem_rsp_data | input | 64 | Sub-block read data |

## Verification
Several properties are checked on every cycle. Loads are accepted only on a hit, and each accepted load produces a response on the next cycle. Refill reads are 8-byte aligned and stall the processor. A memory request is held stable until it is taken, and each accepted store becomes a word write that blocks the processor. A clear leaves no hit behind. Which sub-blocks a tag change invalidates, the byte merging of partial stores, the no-allocate bypass and the returned data values can only be seen through the bench's sweeps. The bench checks these against a memory image and a hit/miss prediction it keeps itself.

// File: rtl/sbc_pkg.sv
// Shared types for the sub-block-valid direct-mapped cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FILL_REQ  = 2'd1,
        ST_FILL_WAIT = 2'd2,
        ST_STORE     = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
// Tag and per-sub-block valid storage for a direct-mapped cache.
// Does: combinational lookup (tag match AND addressed valid flag), refill update
//       that resets sibling flags on a tag change, and a single-cycle clear of all flags.
// Assumes: clear has priority over a refill in the same cycle; tags are not reset.
module sbc_tag_store #(
    parameter int NUM_FRAMES = 32,
    parameter int SUBS       = 4,
    parameter int TAG_W      = 22,
    localparam int IDX_W     = $clog2(NUM_FRAMES),
    localparam int SSEL_W    = $clog2(SUBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [SSEL_W-1:0] lk_sub,
    output logic              lk_hit,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [SSEL_W-1:0] fill_sub
);
    logic [TAG_W-1:0] tag_q [NUM_FRAMES];
    logic [SUBS-1:0]  vld_q [NUM_FRAMES];

    // Lookup: hit needs a matching tag and the addressed sub-block flag.
    always_comb begin
        lk_hit = vld_q[lk_idx][lk_sub] && (tag_q[lk_idx] == lk_tag);
    end

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic sel;
        logic same_tag;
        assign sel      = fill_en && (fill_idx == IDX_W'(f));
        assign same_tag = (tag_q[f] == fill_tag);

        // Tag register: written on every refill of this frame.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[f] <= fill_tag;
            end
        end

        // Valid flags: reset/clear, else keep siblings only if tag unchanged.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                vld_q[f] <= '0;
            end else if (sel) begin
                vld_q[f] <= (same_tag ? vld_q[f] : '0) | (SUBS'(1) << fill_sub);
            end
        end
    end
endmodule

// File: rtl/sbc_data_store.sv
// Data array of a direct-mapped cache, one entry per sub-block.
// Does: asynchronous word read, whole-sub-block refill write, byte-enabled word write.
// Assumes: refill and processor write never occur in the same cycle.
module sbc_data_store #(
    parameter int SLOTS     = 128,
    parameter int SUB_W     = 64,
    parameter int WORD_W    = 32,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int WPS      = SUB_W / WORD_W,
    localparam int WSEL_W   = $clog2(WPS),
    localparam int WBYTES   = WORD_W / 8
) (
    input  logic              clk,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [SUB_W-1:0]  fill_data,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WBYTES-1:0] wr_be
);
    logic [SUB_W-1:0] arr_q [SLOTS];

    // Read port: select one word of the addressed sub-block.
    always_comb begin
        rd_data = arr_q[rd_slot][rd_word*WORD_W +: WORD_W];
    end

    // Write port: full sub-block on refill, enabled bytes on store hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            arr_q[fill_slot] <= fill_data;
        end else if (wr_en) begin
            for (int b = 0; b < WBYTES; b++) begin
                if (wr_be[b]) begin
                    arr_q[wr_slot][wr_word*WORD_W + b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sbc_ctrl.sv
// Sequencer for the sub-block cache: lookup, sub-block refill, write-through store.
// Does: decides processor ready, launches refills on read misses and allocating
//       store misses, and holds the memory request until taken.
// Assumes: processor holds its request while ready is low; one refill in flight.
module sbc_ctrl
    import sbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    input  logic        cpu_req_we,
    input  logic        wr_alloc,
    input  logic        lk_hit,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    output logic        cpu_req_ready,
    output logic        acc_rd,
    output logic        acc_wr,
    output logic        start_fill,
    output logic        fill_done,
    output logic        mem_req_valid,
    output logic        mem_req_we
);
    ctrl_state_e state_q, state_d;
    logic        idle;

    // Acceptance and miss detection from the current lookup.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        cpu_req_ready = idle && (lk_hit || (cpu_req_we && !wr_alloc));
        acc_rd        = cpu_req_valid && cpu_req_ready && !cpu_req_we;
        acc_wr        = cpu_req_valid && cpu_req_ready && cpu_req_we;
        start_fill    = idle && cpu_req_valid && !lk_hit && (!cpu_req_we || wr_alloc);
        fill_done     = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
        mem_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_STORE);
        mem_req_we    = (state_q == ST_STORE);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_fill)  state_d = ST_FILL_REQ;
                else if (acc_wr) state_d = ST_STORE;
            end
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
            ST_STORE:     if (mem_req_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/subblk_dm_cache.sv
// Top of the direct-mapped cache with per-sub-block valid flags.
// Does: splits the address, wires tag/data stores to the sequencer, captures
//       miss and store addresses, drives the memory port and the load response.
// Assumes: memory answers each sub-block read with one response pulse, at least
//          one cycle after taking the request.
module subblk_dm_cache #(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int NUM_FRAMES  = 32,
    parameter int BLOCK_BYTES = 32,
    parameter int SUB_BYTES   = 8,
    localparam int WBYTES     = WORD_W / 8,
    localparam int SUB_W      = SUB_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              wr_alloc,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    input  logic [WBYTES-1:0] cpu_req_be,
    output logic              cpu_rsp_valid,
    output logic [WORD_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    output logic [WBYTES-1:0] mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [SUB_W-1:0]  mem_rsp_data
);
    localparam int SUBS    = BLOCK_BYTES / SUB_BYTES;
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int IDX_W   = $clog2(NUM_FRAMES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int SSEL_W  = $clog2(SUBS);
    localparam int SUB_LSB = $clog2(SUB_BYTES);
    localparam int WSEL_W  = $clog2(SUB_BYTES / WBYTES);
    localparam int BSEL_W  = $clog2(WBYTES);
    localparam int SLOTS   = NUM_FRAMES * SUBS;
    localparam int SLOT_W  = IDX_W + SSEL_W;

    logic [TAG_W-1:0]  a_tag, m_tag;
    logic [IDX_W-1:0]  a_idx, m_idx;
    logic [SSEL_W-1:0] a_sub, m_sub;
    logic [WSEL_W-1:0] a_word;
    logic              lk_hit;
    logic              acc_rd, acc_wr, start_fill, fill_done, req_we;
    logic [ADDR_W-1:0] miss_addr_q, st_addr_q;
    logic [WORD_W-1:0] st_data_q, rd_word_data;
    logic [WBYTES-1:0] st_be_q;
    logic              rsp_vld_q;
    logic [WORD_W-1:0] rsp_data_q;

    // Address fields of the live request and of the captured miss.
    always_comb begin
        a_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
        a_idx  = cpu_req_addr[OFF_W +: IDX_W];
        a_sub  = cpu_req_addr[SUB_LSB +: SSEL_W];
        a_word = cpu_req_addr[BSEL_W +: WSEL_W];
        m_tag  = miss_addr_q[ADDR_W-1 -: TAG_W];
        m_idx  = miss_addr_q[OFF_W +: IDX_W];
        m_sub  = miss_addr_q[SUB_LSB +: SSEL_W];
    end

    sbc_tag_store #(
        .NUM_FRAMES (NUM_FRAMES),
        .SUBS       (SUBS),
        .TAG_W      (TAG_W)
    ) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (inval),
        .lk_idx   (a_idx),
        .lk_tag   (a_tag),
        .lk_sub   (a_sub),
        .lk_hit   (lk_hit),
        .fill_en  (fill_done),
        .fill_idx (m_idx),
        .fill_tag (m_tag),
        .fill_sub (m_sub)
    );

    sbc_data_store #(
        .SLOTS  (SLOTS),
        .SUB_W  (SUB_W),
        .WORD_W (WORD_W)
    ) i_data (
        .clk       (clk),
        .rd_slot   (SLOT_W'({a_idx, a_sub})),
        .rd_word   (a_word),
        .rd_data   (rd_word_data),
        .fill_en   (fill_done),
        .fill_slot (SLOT_W'({m_idx, m_sub})),
        .fill_data (mem_rsp_data),
        .wr_en     (acc_wr && lk_hit),
        .wr_slot   (SLOT_W'({a_idx, a_sub})),
        .wr_word   (a_word),
        .wr_data   (cpu_req_wdata),
        .wr_be     (cpu_req_be)
    );

    sbc_ctrl i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_we    (cpu_req_we),
        .wr_alloc      (wr_alloc),
        .lk_hit        (lk_hit),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .cpu_req_ready (cpu_req_ready),
        .acc_rd        (acc_rd),
        .acc_wr        (acc_wr),
        .start_fill    (start_fill),
        .fill_done     (fill_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (req_we)
    );

    // Capture the missing address when a refill is launched.
    always_ff @(posedge clk) begin
        if (start_fill) miss_addr_q <= cpu_req_addr;
    end

    // Capture the store that must be written through.
    always_ff @(posedge clk) begin
        if (acc_wr) begin
            st_addr_q <= cpu_req_addr;
            st_data_q <= cpu_req_wdata;
            st_be_q   <= cpu_req_be;
        end
    end

    // Load response register: one-cycle pulse after an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_q  <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            rsp_vld_q <= acc_rd;
            if (acc_rd) rsp_data_q <= rd_word_data;
        end
    end

    // Memory port: aligned sub-block read or aligned word write.
    always_comb begin
        mem_req_we    = req_we;
        mem_req_addr  = req_we ? {st_addr_q[ADDR_W-1:BSEL_W], BSEL_W'(0)}
                               : {miss_addr_q[ADDR_W-1:SUB_LSB], SUB_LSB'(0)};
        mem_req_wdata = st_data_q;
        mem_req_be    = st_be_q;
        cpu_rsp_valid = rsp_vld_q;
        cpu_rsp_rdata = rsp_data_q;
    end
endmodule

// File: rtl/sbc_checker.sv
// Cycle-level properties of the sub-block cache, bound to the top module.
// Assumes: lk_hit is the lookup result for the live processor address.
module sbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        inval,
    input logic        wr_alloc,
    input logic        cpu_req_valid,
    input logic        cpu_req_ready,
    input logic        cpu_req_we,
    input logic [31:0] cpu_req_addr,
    input logic        cpu_rsp_valid,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [31:0] mem_req_addr,
    input logic        lk_hit
);
    logic acc_rd, acc_wr;
    assign acc_rd = cpu_req_valid && cpu_req_ready && !cpu_req_we;
    assign acc_wr = cpu_req_valid && cpu_req_ready && cpu_req_we;

    AST_LOAD_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |-> lk_hit);                                              // R2
    AST_LOAD_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> cpu_rsp_valid);                                       // R2
    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> $past(acc_rd));                                // R2
    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr[2:0] == 3'b000)); // R3
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> !cpu_req_ready);              // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr))); // R7
    AST_STORE_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (mem_req_valid && mem_req_we &&
                    mem_req_addr == {$past(cpu_req_addr[31:2]), 2'b00})); // R7
    AST_STORE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> !cpu_req_ready);               // R7
    AST_ALLOC_NO_MISS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !lk_hit) |-> !wr_alloc);                              // R9
    AST_CLEAR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !lk_hit);                                              // R11
endmodule

bind subblk_dm_cache sbc_checker i_sbc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .inval         (inval),
    .wr_alloc      (wr_alloc),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .lk_hit        (lk_hit)
);

// File: tb/test_subblk_dm_cache.sv
// Self-checking bench: memory image over a 4 KB window, hit/miss prediction
// from the requirements, sweeps over frames, sub-blocks, tags and byte enables.
module test_subblk_dm_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval = 1'b0;
    logic        wr_alloc = 1'b1;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_we = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic [3:0]  cpu_req_be = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #5 clk = ~clk;

    subblk_dm_cache i_subblk_dm_cache (.*);

    int          n_chk = 0, n_fail = 0;
    logic [31:0] bmem [1024];
    int          rd_count = 0, wr_count = 0;
    logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
    logic [3:0]  last_wr_be;
    bit          stall_mode = 1'b0;
    bit          done = 1'b0;
    int          ref_tag [32];
    bit [3:0]    ref_v [32];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: ready pattern, write updates, delayed sub-block data.
    initial begin
        int cyc = 0;
        int rsp_cnt = 0;
        logic [31:0] pend = '0;
        for (int i = 0; i < 1024; i++) bmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = {bmem[pend[11:2] + 10'd1], bmem[pend[11:2]]};
                end
            end
            mem_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_req_be[b]) bmem[mem_req_addr[11:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
                    last_wr_addr = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                    last_wr_be   = mem_req_be;
                    wr_count++;
                end else begin
                    pend         = mem_req_addr;
                    last_rd_addr = mem_req_addr;
                    rsp_cnt      = 2;
                    rd_count++;
                end
            end
        end
    end

    // One processor access with prediction and checks; req labels the scenario.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, input string req);
        int idx = int'(addr[9:5]);
        int sub = int'(addr[4:3]);
        int tg  = int'(addr[31:10]);
        bit hit = ref_v[idx][sub] && (ref_tag[idx] == tg);
        bit fills = !hit && (!we || wr_alloc);
        int rd0 = rd_count;
        int wr0 = wr_count;
        logic [31:0] exp;
        @(negedge clk); #1;
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr;
        cpu_req_wdata = wd; cpu_req_be = be;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #2; end
        @(negedge clk); #1;
        cpu_req_valid = 1'b0;
        chk((rd_count - rd0) == (fills ? 1 : 0), req, "refill count", 64'(rd_count - rd0), 64'(fills));
        if (fills) chk(last_rd_addr == {addr[31:3], 3'b000}, req, "refill address",
                       64'(last_rd_addr), 64'({addr[31:3], 3'b000}));
        if (fills) begin
            if (ref_tag[idx] != tg) ref_v[idx] = 4'b0000;
            ref_tag[idx] = tg;
            ref_v[idx][sub] = 1'b1;
        end
        if (!we) begin
            exp = bmem[addr[11:2]];
            chk(cpu_rsp_valid == 1'b1, req, "response valid", 64'(cpu_rsp_valid), 64'd1);
            chk(cpu_rsp_rdata == exp, req, "load data", 64'(cpu_rsp_rdata), 64'(exp));
        end else begin
            while (wr_count == wr0) begin @(negedge clk); #1; end
            chk(last_wr_addr == {addr[31:2], 2'b00} && last_wr_data == wd && last_wr_be == be,
                "R7", "store written through", {last_wr_addr, last_wr_data}, {addr[31:2], 2'b00, wd});
        end
    endtask

    task automatic clear_all();
        @(negedge clk); #1;
        inval = 1'b1;
        @(negedge clk); #1;
        inval = 1'b0;
        for (int f = 0; f < 32; f++) ref_v[f] = 4'b0000;
    endtask

    function automatic logic [31:0] mk(input int tg, input int f, input int s, input int w);
        return 32'((tg << 10) | (f << 5) | (s << 3) | (w << 2));
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 32; f++) begin ref_tag[f] = 0; ref_v[f] = 4'b0000; end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        #1;
        // R12: reset state and a cold lookup.
        chk(mem_req_valid == 1'b0, "R12", "memory request after reset", 64'(mem_req_valid), 64'd0);
        chk(cpu_rsp_valid == 1'b0, "R12", "response after reset", 64'(cpu_rsp_valid), 64'd0);
        chk(cpu_req_ready == 1'b0, "R12", "cold lookup not a hit", 64'(cpu_req_ready), 64'd0);

        // R1 R3 R5: first touch of every sub-block with tag 0.
        for (int f = 0; f < 32; f++)
            for (int s = 0; s < 4; s++) access(1'b0, mk(0, f, s, s % 2), '0, '0, "R3");
        // R2 R4: every word of tag 0 now hits.
        for (int f = 0; f < 32; f++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++) access(1'b0, mk(0, f, s, w), '0, '0, "R2");
        // R1 R5: tag 1 into each frame, then siblings of both tags miss.
        for (int f = 0; f < 32; f++) begin
            access(1'b0, mk(1, f, f % 4, 0), '0, '0, "R1");
            access(1'b0, mk(1, f, (f + 1) % 4, 1), '0, '0, "R5");
            access(1'b0, mk(0, f, (f + 2) % 4, 0), '0, '0, "R5");
        end
        // R6: same-tag refills keep earlier sub-blocks valid.
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 4; s++) access(1'b0, mk(0, f, s, 1), '0, '0, "R6");
            for (int s = 0; s < 4; s++) access(1'b0, mk(0, f, s, 0), '0, '0, "R6");
        end

        stall_mode = 1'b1;
        // R7 R8: store hits with every byte-enable pattern, read back merged.
        for (int be = 0; be < 16; be++) begin
            access(1'b1, mk(0, 3, be % 4, be % 2), 32'hA0B0C0D0 + be, 4'(be), "R8");
            access(1'b0, mk(0, 3, be % 4, be % 2), '0, '0, "R8");
            access(1'b0, mk(0, 3, be % 4, 1 - be % 2), '0, '0, "R8");
        end
        // R9: allocating store misses, then loads hit the merged word.
        wr_alloc = 1'b1;
        for (int f = 10; f < 14; f++) begin
            access(1'b1, mk(2, f, 2, 1), 32'h1234_0000 + f, 4'b0110, "R9");
            access(1'b0, mk(2, f, 2, 1), '0, '0, "R9");
            access(1'b0, mk(2, f, 2, 0), '0, '0, "R9");
        end
        // R10: bypassing store misses leave the frame's line intact.
        wr_alloc = 1'b0;
        for (int f = 16; f < 20; f++) begin
            access(1'b0, mk(0, f, 0, 0), '0, '0, "R10");
            access(1'b1, mk(3, f, 0, 0), 32'hDEAD_0000 + f, 4'b1111, "R10");
            access(1'b0, mk(0, f, 0, 0), '0, '0, "R10");
            access(1'b0, mk(3, f, 0, 0), '0, '0, "R10");
            access(1'b1, mk(3, f, 0, 1), 32'hBEEF_0000 + f, 4'b1001, "R10");
            access(1'b0, mk(3, f, 0, 1), '0, '0, "R10");
        end
        wr_alloc = 1'b1;
        stall_mode = 1'b0;
        // R11: clear drops everything; previously hitting words refill.
        for (int f = 0; f < 4; f++) access(1'b0, mk(0, f, 1, 0), '0, '0, "R11");
        clear_all();
        for (int f = 0; f < 4; f++) access(1'b0, mk(0, f, 1, 0), '0, '0, "R11");
        for (int f = 0; f < 4; f++) access(1'b0, mk(0, f, 1, 1), '0, '0, "R11");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule